// File: doc/BRIEF.md
# Slot Power Limit Enforcement Controller

This block holds the slot power limit most recently granted by the upstream port. The limit has a scale field and a value field, and a new limit arrives as a decoded set-limit message. Each time the link reset is released, and each time a fresh limit message lands, the block compares the held limit against a programmed floor. The floor is also a scale and a value. If the granted limit falls under that floor, the block applies one of several responses chosen by a 3-bit policy code.

The responses are:
- do nothing;
- raise a power-override level;
- switch off the secondary clocks selected by a clock mask;
- both of the previous two;
- enter a rejection mode. In this mode every incoming transaction other than a configuration access (type 0 or type 1) is marked for an unsupported-request completion.

The block produces control levels only. Message decoding, transaction handling and the clock gating cells sit in the surrounding logic.

Top module: `slot_pwr_guard`

## Requirements
- R1: While `link_rst_n` is low, `pwr_ovrd`, `clk_disable`, `ur_mode` and `txn_ur` are all low, and the evaluated response is cleared to "none".
- R2: When `msg_valid` is high at a rising clock edge, `msg_scale` and `msg_value` are stored as the held limit. The held limit does not change at any other edge. It is cleared to zero only by `rst_n`, and it is kept through a link reset.
- R3: An evaluation is triggered by the first rising edge after `link_rst_n` goes high, and by any rising edge at which `msg_valid` is high. The outputs take the evaluated response at the following rising edge. At the triggering edge itself, the outputs keep their previous response.
- R4: The limit counts as under the floor only when the held scale is below `min_scale` and the held value is below `min_value`, each compared as an unsigned number. Otherwise the evaluated response is "none" whatever the policy code.
- R5: When the limit is under the floor, `policy_sel` selects the response:
  - 0: none;
  - 1: `pwr_ovrd` high;
  - 2: clocks off;
  - 3: clocks off and `pwr_ovrd` high;
  - 4: `ur_mode` high with `pwr_ovrd` low and no clocks off;
  - 5, 6 and 7: treated as none.
- R6: `clk_disable` equals `clk_mask` (live) bitwise-ANDed with all ones while the response is 2 or 3. It is zero otherwise.
- R7: `txn_ur` is high exactly when `txn_valid` is high, `ur_mode` is high and `txn_is_cfg` is low. Configuration accesses are never marked.
- R8: Between triggers the evaluated response holds. Changes to `min_scale`, `min_value` or `policy_sel` have no effect on the outputs until the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset for the held limit |
| link_rst_n | input | 1 | Asynchronous active-low link reset; release triggers an evaluation |
| msg_valid | input | 1 | One-cycle strobe: a set-limit message was decoded |
| msg_scale | input | SCALE_W | Scale field of the received limit |
| msg_value | input | VALUE_W | Value field of the received limit |
| min_scale | input | SCALE_W | Programmed floor, scale part |
| min_value | input | VALUE_W | Programmed floor, value part |
| policy_sel | input | 3 | Response selection code |
| clk_mask | input | NUM_CLK | Secondary clocks that may be switched off |
| txn_valid | input | 1 | A transaction is presented |
| txn_is_cfg | input | 1 | Presented transaction is a type 0/1 configuration access |
| pwr_ovrd | output | 1 | Power-override level |
| clk_disable | output | NUM_CLK | Per-clock disable levels |
| ur_mode | output | 1 | Unsupported-request rejection mode active |
| txn_ur | output | 1 | Presented transaction is to be answered with unsupported request |

## Verification
The bench builds the block with SCALE_W=2, VALUE_W=3 and NUM_CLK=4. This shrinks the compare space to 4×8 limits against 4×8 floors. The sweep can then cover every limit/floor pairing under all eight policy codes, including the unused ones. A separate pass walks every clock mask and every transaction kind in rejection mode. Timing checks sample one edge after each trigger and two edges after it. Link-reset passes confirm that a held limit survives a link reset and is evaluated again on release.

// File: rtl/spl_pkg.sv
package spl_pkg;

  typedef enum logic [2:0] {
    ACT_NONE = 3'd0,
    ACT_OVRD = 3'd1,
    ACT_CLK  = 3'd2,
    ACT_BOTH = 3'd3,
    ACT_UR   = 3'd4
  } spl_act_e;

  // Map a raw policy code to a response; unused codes fall back to none.
  function automatic spl_act_e policy_decode(input logic [2:0] code);
    spl_act_e r;
    case (code)
      3'd1:    r = ACT_OVRD;
      3'd2:    r = ACT_CLK;
      3'd3:    r = ACT_BOTH;
      3'd4:    r = ACT_UR;
      default: r = ACT_NONE;
    endcase
    return r;
  endfunction

  function automatic logic act_has_ovrd(input spl_act_e a);
    return (a == ACT_OVRD) || (a == ACT_BOTH);
  endfunction

  function automatic logic act_has_clk(input spl_act_e a);
    return (a == ACT_CLK) || (a == ACT_BOTH);
  endfunction

endpackage

// File: rtl/spl_capture.sv
module spl_capture #(
  parameter int SCALE_W = 2,
  parameter int VALUE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_valid,
  input  logic [SCALE_W-1:0] msg_scale,
  input  logic [VALUE_W-1:0] msg_value,
  output logic [SCALE_W-1:0] cap_scale,
  output logic [VALUE_W-1:0] cap_value
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_scale <= '0;
      cap_value <= '0;
    end else if (msg_valid) begin
      cap_scale <= msg_scale;
      cap_value <= msg_value;
    end
  end

  // R2: a message lands in the held limit
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> (cap_scale == $past(msg_scale)) && (cap_value == $past(msg_value)));

  // R2: without a message the held limit holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> $stable(cap_scale) && $stable(cap_value));

endmodule

// File: rtl/spl_eval.sv
module spl_eval
  import spl_pkg::*;
#(
  parameter int SCALE_W = 2,
  parameter int VALUE_W = 8
) (
  input  logic               clk,
  input  logic               link_rst_n,
  input  logic               msg_valid,
  input  logic [SCALE_W-1:0] cap_scale,
  input  logic [VALUE_W-1:0] cap_value,
  input  logic [SCALE_W-1:0] min_scale,
  input  logic [VALUE_W-1:0] min_value,
  input  logic [2:0]         policy_sel,
  output spl_act_e           act,
  output logic               eval_go,
  output logic               limit_low
);

  logic link_up;

  // Both fields must sit under their floors for the limit to count as low.
  function automatic logic below_min(
    input logic [SCALE_W-1:0] s, input logic [SCALE_W-1:0] ms,
    input logic [VALUE_W-1:0] v, input logic [VALUE_W-1:0] mv);
    return (s < ms) && (v < mv);
  endfunction

  assign limit_low = below_min(cap_scale, min_scale, cap_value, min_value);

  always_ff @(posedge clk or negedge link_rst_n) begin
    if (!link_rst_n) begin
      link_up <= 1'b0;
      eval_go <= 1'b0;
      act     <= ACT_NONE;
    end else begin
      link_up <= 1'b1;
      eval_go <= !link_up || msg_valid;
      if (eval_go)
        act <= limit_low ? policy_decode(policy_sel) : ACT_NONE;
    end
  end

  // R3: the first edge after link release starts an evaluation
  a_r3_release_trigger: assert property (@(posedge clk) disable iff (!link_rst_n)
    $rose(link_up) |-> eval_go);

  // R3: a message starts an evaluation one edge later
  a_r3_msg_trigger: assert property (@(posedge clk) disable iff (!link_rst_n)
    msg_valid |=> eval_go);

  // R8: the response holds between triggers
  a_r8_hold: assert property (@(posedge clk) disable iff (!link_rst_n)
    !eval_go |=> $stable(act));

  // R4: a limit at or over the floor leads to no response
  a_r4_no_action: assert property (@(posedge clk) disable iff (!link_rst_n)
    (eval_go && !limit_low) |=> (act == ACT_NONE));

endmodule

// File: rtl/spl_action.sv
module spl_action
  import spl_pkg::*;
#(
  parameter int NUM_CLK = 5
) (
  input  logic               clk,
  input  logic               link_rst_n,
  input  spl_act_e           act,
  input  logic [NUM_CLK-1:0] clk_mask,
  input  logic               txn_valid,
  input  logic               txn_is_cfg,
  output logic               pwr_ovrd,
  output logic [NUM_CLK-1:0] clk_disable,
  output logic               ur_mode,
  output logic               txn_ur
);

  logic clk_off;

  assign pwr_ovrd = act_has_ovrd(act);
  assign clk_off  = act_has_clk(act);
  assign ur_mode  = (act == ACT_UR);

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_gate
    assign clk_disable[g] = clk_mask[g] & clk_off;
  end

  assign txn_ur = txn_valid && ur_mode && !txn_is_cfg;

  // R5: rejection mode excludes the other responses
  a_r5_ur_exclusive: assert property (@(posedge clk) disable iff (!link_rst_n)
    ur_mode |-> (!pwr_ovrd && (clk_disable == '0)));

  // R6: no clock outside the mask is ever switched off
  a_r6_mask_bound: assert property (@(posedge clk) disable iff (!link_rst_n)
    (clk_disable & ~clk_mask) == '0);

  // R7: configuration accesses are never rejected
  a_r7_cfg_pass: assert property (@(posedge clk) disable iff (!link_rst_n)
    txn_is_cfg |-> !txn_ur);

endmodule

// File: rtl/slot_pwr_guard.sv
module slot_pwr_guard
  import spl_pkg::*;
#(
  parameter int SCALE_W = 2,
  parameter int VALUE_W = 8,
  parameter int NUM_CLK = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_rst_n,
  input  logic               msg_valid,
  input  logic [SCALE_W-1:0] msg_scale,
  input  logic [VALUE_W-1:0] msg_value,
  input  logic [SCALE_W-1:0] min_scale,
  input  logic [VALUE_W-1:0] min_value,
  input  logic [2:0]         policy_sel,
  input  logic [NUM_CLK-1:0] clk_mask,
  input  logic               txn_valid,
  input  logic               txn_is_cfg,
  output logic               pwr_ovrd,
  output logic [NUM_CLK-1:0] clk_disable,
  output logic               ur_mode,
  output logic               txn_ur
);

  logic [SCALE_W-1:0] cap_scale;
  logic [VALUE_W-1:0] cap_value;
  spl_act_e           act;
  logic               eval_go;
  logic               limit_low;

  spl_capture #(.SCALE_W(SCALE_W), .VALUE_W(VALUE_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_scale (msg_scale),
    .msg_value (msg_value),
    .cap_scale (cap_scale),
    .cap_value (cap_value)
  );

  spl_eval #(.SCALE_W(SCALE_W), .VALUE_W(VALUE_W)) u_eval (
    .clk        (clk),
    .link_rst_n (link_rst_n),
    .msg_valid  (msg_valid),
    .cap_scale  (cap_scale),
    .cap_value  (cap_value),
    .min_scale  (min_scale),
    .min_value  (min_value),
    .policy_sel (policy_sel),
    .act        (act),
    .eval_go    (eval_go),
    .limit_low  (limit_low)
  );

  spl_action #(.NUM_CLK(NUM_CLK)) u_act (
    .clk         (clk),
    .link_rst_n  (link_rst_n),
    .act         (act),
    .clk_mask    (clk_mask),
    .txn_valid   (txn_valid),
    .txn_is_cfg  (txn_is_cfg),
    .pwr_ovrd    (pwr_ovrd),
    .clk_disable (clk_disable),
    .ur_mode     (ur_mode),
    .txn_ur      (txn_ur)
  );

  // R1: everything quiet while the link is in reset
  always @(posedge clk) begin
    if (!link_rst_n)
      a_r1_quiet: assert (!pwr_ovrd && (clk_disable == '0) && !ur_mode && !txn_ur);
  end

endmodule

// File: tb/slot_pwr_guard_test.sv
module slot_pwr_guard_test;

  localparam int SW = 2;
  localparam int VW = 3;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1, link_rst_n = 1'b1;
  logic          msg_valid = 1'b0;
  logic [SW-1:0] msg_scale = '0, min_scale = '0;
  logic [VW-1:0] msg_value = '0, min_value = '0;
  logic [2:0]    policy_sel = '0;
  logic [NC-1:0] clk_mask = '0;
  logic          txn_valid = 1'b0, txn_is_cfg = 1'b0;
  logic          pwr_ovrd, ur_mode, txn_ur;
  logic [NC-1:0] clk_disable;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  slot_pwr_guard #(.SCALE_W(SW), .VALUE_W(VW), .NUM_CLK(NC)) uut (
    .clk(clk), .rst_n(rst_n), .link_rst_n(link_rst_n),
    .msg_valid(msg_valid), .msg_scale(msg_scale), .msg_value(msg_value),
    .min_scale(min_scale), .min_value(min_value), .policy_sel(policy_sel),
    .clk_mask(clk_mask), .txn_valid(txn_valid), .txn_is_cfg(txn_is_cfg),
    .pwr_ovrd(pwr_ovrd), .clk_disable(clk_disable), .ur_mode(ur_mode),
    .txn_ur(txn_ur)
  );

  // Packed view of the outputs: {pwr_ovrd, ur_mode, clk_disable}
  function automatic logic [NC+1:0] observed();
    return {pwr_ovrd, ur_mode, clk_disable};
  endfunction

  // Expected outputs from the requirement text (R4, R5, R6).
  function automatic logic [NC+1:0] expect_out(int s, int ms, int v, int mv, int p,
                                               logic [NC-1:0] m);
    int code;
    code = ((s < ms) && (v < mv) && (p <= 4)) ? p : 0;
    return {(code == 1 || code == 3), (code == 4),
            ((code == 2 || code == 3) ? m : {NC{1'b0}})};
  endfunction

  task automatic check(string req, logic [NC+1:0] got, logic [NC+1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic send_msg(int s, int v);
    @(negedge clk);
    msg_scale = SW'(s); msg_value = VW'(v); msg_valid = 1'b1;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0; link_rst_n = 1'b0;
    clk_mask = 4'b1111; policy_sel = 3'd3;
    min_scale = 2'd3; min_value = 3'd7;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", observed(), '0);
    check("R1 reset txn_ur", {5'b0, txn_ur}, '0);
    rst_n = 1'b1;
    // Held limit is zero after rst_n; floor 3/7 makes it low; policy 3.
    link_rst_n = 1'b1;
    @(negedge clk);
    check("R3 no change at trigger edge", observed(), '0);
    @(negedge clk);
    check("R3 release evaluation", observed(), expect_out(0, 3, 0, 7, 3, 4'b1111));

    // Exhaustive sweep of limit, floor and policy (R4, R5, R2, R3).
    for (int p = 0; p < 8; p++) begin
      for (int ms = 0; ms < 4; ms++) begin
        for (int mv = 0; mv < 8; mv++) begin
          for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 8; v++) begin
              policy_sel = 3'(p); min_scale = SW'(ms); min_value = VW'(mv);
              clk_mask = NC'(s * 8 + v + p);
              send_msg(s, v);
              @(negedge clk);
              check("R4 R5 sweep", observed(), expect_out(s, ms, v, mv, p, clk_mask));
            end
          end
        end
      end
    end

    // R6: live mask with clock response active.
    policy_sel = 3'd2; min_scale = 2'd2; min_value = 3'd5;
    send_msg(1, 2);
    @(negedge clk);
    for (int m = 0; m < 16; m++) begin
      clk_mask = NC'(m);
      #1;
      check("R6 live mask", observed(), {2'b00, NC'(m)});
    end

    // R8: floor and policy changes have no effect between triggers.
    policy_sel = 3'd1; min_scale = 2'd0; min_value = 3'd0; clk_mask = 4'b1010;
    repeat (3) @(negedge clk);
    check("R8 held response", observed(), {2'b00, 4'b1010});

    // R3: message trigger timing; old response visible one edge after the message.
    policy_sel = 3'd4; min_scale = 2'd3; min_value = 3'd7;
    @(negedge clk);
    msg_scale = 2'd0; msg_value = 3'd0; msg_valid = 1'b1;
    @(negedge clk);
    msg_valid = 1'b0;
    check("R3 old response after message edge", observed(), {2'b00, 4'b1010});
    @(negedge clk);
    check("R3 new response", observed(), {2'b01, 4'b0000});

    // R7: every transaction kind in rejection mode and outside it.
    for (int t = 0; t < 4; t++) begin
      txn_valid = t[0]; txn_is_cfg = t[1];
      #1;
      check("R7 txn ur mode", {5'b0, txn_ur}, {5'b0, (t == 1)});
    end
    policy_sel = 3'd0;
    send_msg(0, 0);
    @(negedge clk);
    for (int t = 0; t < 4; t++) begin
      txn_valid = t[0]; txn_is_cfg = t[1];
      #1;
      check("R7 txn normal mode", {5'b0, txn_ur}, '0);
    end
    txn_valid = 1'b0; txn_is_cfg = 1'b0;

    // R2: held limit survives link reset and is evaluated again on release.
    policy_sel = 3'd3; clk_mask = 4'b0110; min_scale = 2'd3; min_value = 3'd7;
    send_msg(2, 6);
    @(negedge clk);
    check("R2 before link reset", observed(), {2'b10, 4'b0110});
    link_rst_n = 1'b0;
    #1;
    check("R1 link reset clears", observed(), '0);
    @(negedge clk);
    min_value = 3'd6;
    link_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 retained limit re-evaluated", observed(), expect_out(2, 3, 6, 6, 3, 4'b0110));
    min_value = 3'd7;
    link_rst_n = 1'b0;
    @(negedge clk);
    link_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 retained limit low", observed(), {2'b10, 4'b0110});

    // R2: rst_n clears the held limit to zero.
    rst_n = 1'b0; link_rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; link_rst_n = 1'b1; min_scale = 2'd1; min_value = 3'd1; policy_sel = 3'd1;
    repeat (2) @(negedge clk);
    check("R2 cleared limit", observed(), {2'b10, 4'b0000});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule